// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the instruction address of a single-cycle 16-bit processor with a 15-bit instruction space. On every rising clock edge the address register takes a new value. It can advance by one, load a jump target taken from the operand-A register value, or move by a signed displacement relative to its current value. The relative move happens only when the selected status flag of operand A is set.

The displacement is six bits of two's complement. Its upper three bits sit in instruction bits 8:6 and its lower three bits in instruction bits 2:0. Bits 5:3 between them name the operand register and are not used here. The two parts are joined, sign-extended to the address width and added with wrap-around.

Three control inputs choose the action:
- The load enable picks between counting and a loaded value.
- The jump select picks between a jump and a conditional branch.
- The condition select picks which flag the branch tests: the negative flag or the zero flag.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` becomes 0 on that edge, whatever the other inputs are.
- R2: With `load_en` low, `pc_q` becomes `pc_q`+1 at each edge; `jump_sel`, `cond_neg`, `flag_neg`, `flag_zero`, `instr` and `src_a_data` have no effect.
- R3: With `load_en` high and `jump_sel` high, `pc_q` becomes `src_a_data[14:0]`; bit 15 of `src_a_data`, both flags and `instr` have no effect.
- R4: With `load_en` high, `jump_sel` low and `cond_neg` high, `pc_q` moves by the displacement when `flag_neg` is 1 and otherwise increments; `flag_zero` has no effect.
- R5: With `load_en` high, `jump_sel` low and `cond_neg` low, `pc_q` moves by the displacement when `flag_zero` is 1 and otherwise increments; `flag_neg` has no effect.
- R6: The displacement is {`instr[8:6]`, `instr[2:0]`} read as a 6-bit two's complement value in -32..+31; instruction bits 15:9 and 5:3 do not change it.
- R7: All address arithmetic wraps modulo 2^15: 0x7FFF+1 gives 0, and a branch beyond either end of the space wraps around.
- R8: The instruction word 0xC174 carries displacement -20, so a taken zero-flag branch from address 100 lands on 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Current instruction word |
| load_en | input | 1 | 0: count up, 1: load a jump or branch result |
| jump_sel | input | 1 | With load_en high: 1 jump, 0 conditional branch |
| cond_neg | input | 1 | Branch condition: 1 tests flag_neg, 0 tests flag_zero |
| src_a_data | input | 16 | Operand-A register value (jump target) |
| flag_neg | input | 1 | Operand A is negative |
| flag_zero | input | 1 | Operand A is zero |
| pc_q | output | 15 | Current instruction address |

## Verification
The address register feeds back into its own next value. Any wrong state therefore appears on `pc_q` one edge after it forms, and every later count or branch carries it forward. Three kinds of fault show up in different ways. A wrong action choice gives an address that differs by the displacement or the jump target at the very next edge. A wrong displacement field mapping or a missing sign extension shows only on branches whose two fields differ or whose top bit is set. A missing wrap shows only next to 0x0000 or 0x7FFF. For these reasons the stimulus places branches with asymmetric fields and extreme offsets right next to both ends of the address space.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  localparam int unsigned PC_INSTR_W = 16;
  localparam int unsigned PC_ADDR_W  = 15;

  // Displacement field placement inside the instruction word
  localparam int unsigned DISP_PART_W = 3;
  localparam int unsigned DISP_HI_LSB = 6;
  localparam int unsigned DISP_LO_LSB = 0;

  typedef enum logic [1:0] {
    ACT_COUNT  = 2'd0,
    ACT_JUMP   = 2'd1,
    ACT_BRANCH = 2'd2
  } pc_action_e;

endpackage

// File: rtl/pc_disp_extract.sv
module pc_disp_extract
  import pc_seq_pkg::*;
#(
  parameter int unsigned INSTR_W = PC_INSTR_W,
  parameter int unsigned ADDR_W  = PC_ADDR_W,
  parameter int unsigned PART_W  = DISP_PART_W,
  parameter int unsigned HI_LSB  = DISP_HI_LSB,
  parameter int unsigned LO_LSB  = DISP_LO_LSB
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [ADDR_W-1:0]  disp_ext
);

  localparam int unsigned DISP_W = 2 * PART_W;

  logic [PART_W-1:0] part_hi;
  logic [PART_W-1:0] part_lo;
  logic [DISP_W-1:0] disp_raw;

  assign part_hi  = instr[HI_LSB +: PART_W];
  assign part_lo  = instr[LO_LSB +: PART_W];
  assign disp_raw = {part_hi, part_lo};

  generate
    if (ADDR_W > DISP_W) begin : g_extend
      assign disp_ext = {{(ADDR_W-DISP_W){disp_raw[DISP_W-1]}}, disp_raw};
    end else begin : g_trunc
      assign disp_ext = disp_raw[ADDR_W-1:0];
    end
  endgenerate

  // R6: low bits of the extended value follow the two fields
  always_comb begin
    assert_disp_fields_R6: assert (disp_ext[DISP_W-1:0] ==
      {instr[HI_LSB +: PART_W], instr[LO_LSB +: PART_W]});
  end

endmodule

// File: rtl/pc_next_select.sv
module pc_next_select
  import pc_seq_pkg::*;
#(
  parameter int unsigned INSTR_W = PC_INSTR_W,
  parameter int unsigned ADDR_W  = PC_ADDR_W
) (
  input  logic [ADDR_W-1:0]  pc_cur,
  input  logic [ADDR_W-1:0]  disp_ext,
  input  logic [INSTR_W-1:0] src_a_data,
  input  logic               load_en,
  input  logic               jump_sel,
  input  logic               cond_neg,
  input  logic               flag_neg,
  input  logic               flag_zero,
  output pc_action_e         action,
  output logic [ADDR_W-1:0]  pc_nxt
);

  function automatic logic [ADDR_W-1:0] wrap_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  logic cond_met;
  logic unused_src_hi;

  assign cond_met      = cond_neg ? flag_neg : flag_zero;
  assign unused_src_hi = ^src_a_data[INSTR_W-1:ADDR_W];

  always_comb begin
    if (!load_en)      action = ACT_COUNT;
    else if (jump_sel) action = ACT_JUMP;
    else if (cond_met) action = ACT_BRANCH;
    else               action = ACT_COUNT;
  end

  always_comb begin
    unique case (action)
      ACT_JUMP:   pc_nxt = src_a_data[ADDR_W-1:0];
      ACT_BRANCH: pc_nxt = wrap_add(pc_cur, disp_ext);
      default:    pc_nxt = wrap_inc(pc_cur);
    endcase
  end

  // R2: counting is chosen whenever the load enable is low
  always_comb begin
    if (!load_en) assert_count_sel_R2: assert (action == ACT_COUNT);
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int unsigned INSTR_W = PC_INSTR_W,
  parameter int unsigned ADDR_W  = PC_ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic               load_en,
  input  logic               jump_sel,
  input  logic               cond_neg,
  input  logic [INSTR_W-1:0] src_a_data,
  input  logic               flag_neg,
  input  logic               flag_zero,
  output logic [ADDR_W-1:0]  pc_q
);

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] pc_nxt;
  pc_action_e        action;

  pc_disp_extract #(
    .INSTR_W (INSTR_W),
    .ADDR_W  (ADDR_W)
  ) u_disp (
    .instr    (instr),
    .disp_ext (disp_ext)
  );

  pc_next_select #(
    .INSTR_W (INSTR_W),
    .ADDR_W  (ADDR_W)
  ) u_sel (
    .pc_cur     (pc_q),
    .disp_ext   (disp_ext),
    .src_a_data (src_a_data),
    .load_en    (load_en),
    .jump_sel   (jump_sel),
    .cond_neg   (cond_neg),
    .flag_neg   (flag_neg),
    .flag_zero  (flag_zero),
    .action     (action),
    .pc_nxt     (pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  // Named events for the checks below
  logic ev_branch_neg_miss;
  logic ev_branch_zero_miss;
  assign ev_branch_neg_miss  = load_en && !jump_sel &&  cond_neg && !flag_neg;
  assign ev_branch_zero_miss = load_en && !jump_sel && !cond_neg && !flag_zero;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> pc_q == '0);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1)));

  assert_jump_load_R3: assert property (@(posedge clk) disable iff (rst)
    (load_en && jump_sel) |=> pc_q == $past(src_a_data[ADDR_W-1:0]));

  assert_neg_miss_R4: assert property (@(posedge clk) disable iff (rst)
    ev_branch_neg_miss |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1)));

  assert_zero_miss_R5: assert property (@(posedge clk) disable iff (rst)
    ev_branch_zero_miss |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1)));

endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [14:0] exp_pc;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic        load_en = 1'b0;
  logic        jump_sel = 1'b0;
  logic        cond_neg = 1'b0;
  logic [15:0] src_a_data = '0;
  logic        flag_neg = 1'b0;
  logic        flag_zero = 1'b0;
  logic [14:0] pc_q;

  int checks = 0;
  int failures = 0;
  int model_pc = 0;
  bit done = 1'b0;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer uut (
    .clk        (clk),
    .rst        (rst),
    .instr      (instr),
    .load_en    (load_en),
    .jump_sel   (jump_sel),
    .cond_neg   (cond_neg),
    .src_a_data (src_a_data),
    .flag_neg   (flag_neg),
    .flag_zero  (flag_zero),
    .pc_q       (pc_q)
  );

  // Signed 6-bit value from bits 8:6 (high) and 2:0 (low)
  function automatic int offset_of(input logic [15:0] w);
    int v;
    v = int'(w[8:6]) * 8 + int'(w[2:0]);
    if (v >= 32) v = v - 64;
    return v;
  endfunction

  function automatic int wrap15(input int v);
    int r;
    r = v % 32768;
    if (r < 0) r = r + 32768;
    return r;
  endfunction

  task automatic do_reset(input string tag);
    sb_item_t it;
    @(negedge clk);
    rst = 1'b1;
    load_en = 1'b1; jump_sel = 1'b1; src_a_data = 16'h1234;
    model_pc = 0;
    it.exp_pc = 15'd0; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic step(input logic le, input logic js, input logic cn,
                      input logic [15:0] ins, input logic [15:0] a,
                      input logic n, input logic z, input string tag);
    sb_item_t it;
    @(negedge clk);
    rst = 1'b0;
    load_en = le; jump_sel = js; cond_neg = cn;
    instr = ins; src_a_data = a; flag_neg = n; flag_zero = z;
    if (!le)      model_pc = wrap15(model_pc + 1);
    else if (js)  model_pc = int'(a) % 32768;
    else if ((cn && n) || (!cn && z))
                  model_pc = wrap15(model_pc + offset_of(ins));
    else          model_pc = wrap15(model_pc + 1);
    it.exp_pc = 15'(model_pc); it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: one result per rising edge, sampled after it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (pc_q !== it.exp_pc) begin
          failures++;
          $display("FAIL %s pc_q actual=0x%04h expected=0x%04h", it.tag, pc_q, it.exp_pc);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset");
    do_reset("R1 reset held");
    // R2: counting, noise on every other input
    step(0, 0, 0, 16'h0000, 16'h0000, 0, 0, "R2 count");
    step(0, 1, 1, 16'hFFFF, 16'hFFFF, 1, 1, "R2 count ignores controls");
    step(0, 0, 1, 16'h01C7, 16'h7000, 1, 0, "R2 count ignores flags");
    step(0, 1, 0, 16'hC174, 16'h0010, 0, 1, "R2 count ignores jump");
    // R3: jump, top bit of operand dropped
    step(1, 1, 0, 16'h0000, 16'h0064, 0, 0, "R3 jump");
    step(1, 1, 1, 16'h01C7, 16'hABCD, 1, 1, "R3 jump drops bit15");
    // R8: example word from address 100
    step(1, 1, 0, 16'h0000, 16'd100, 0, 0, "R3 jump to 100");
    step(1, 0, 0, 16'hC174, 16'h0000, 0, 1, "R8 branch -20");
    // R4: negative flag branch
    step(1, 0, 1, 16'h00C7, 16'h0000, 1, 0, "R4 neg taken +31");
    step(1, 0, 1, 16'h00C7, 16'h0000, 0, 1, "R4 neg not taken, zero ignored");
    step(1, 0, 1, 16'h0100, 16'h0000, 1, 1, "R4 neg taken -32");
    // R5: zero flag branch
    step(1, 0, 0, 16'h0038, 16'h0000, 1, 0, "R5 zero not taken, neg ignored");
    step(1, 0, 0, 16'h0041, 16'h0000, 0, 1, "R5 zero taken +9");
    step(1, 0, 0, 16'h01FF, 16'h0000, 0, 1, "R5 zero taken -1");
    // R6: other instruction bits do not alter the offset
    step(1, 0, 0, 16'hFE3A, 16'h0000, 0, 1, "R6 noise bits offset 0x32");
    step(1, 0, 0, 16'h0032, 16'h0000, 0, 1, "R6 same offset clean");
    step(1, 0, 1, 16'h00C0, 16'h0000, 1, 0, "R6 high part only +24");
    step(1, 0, 1, 16'h0007, 16'h0000, 1, 0, "R6 low part only +7");
    // R7: wrap-around at both ends
    step(1, 1, 0, 16'h0000, 16'h7FFF, 0, 0, "R7 jump to top");
    step(0, 0, 0, 16'h0000, 16'h0000, 0, 0, "R7 count wraps to 0");
    step(1, 1, 0, 16'h0000, 16'h0002, 0, 0, "R7 jump to 2");
    step(1, 0, 0, 16'hC174, 16'h0000, 0, 1, "R7 branch below 0");
    step(1, 1, 0, 16'h0000, 16'h7FF0, 0, 0, "R7 jump near top");
    step(1, 0, 1, 16'h00C7, 16'h0000, 1, 0, "R7 branch past top");
    do_reset("R1 reset mid-run");
    step(0, 0, 0, 16'h0000, 16'h0000, 0, 0, "R2 count after reset");
    @(negedge clk);
    load_en = 1'b0;
    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule